// File: doc/BRIEF.md
# Daisy-Chained Interrupter Slot Logic

This block is the interrupter side of one module sitting on a backplane with seven prioritised interrupt request lines. Local logic raises a one-cycle request pulse together with the level it wants to use. The block then drives the matching request line and waits for an acknowledge cycle. Each acknowledge cycle arrives on a daisy-chained input and carries the level being serviced on a three-bit code taken from the low address lines.

At the start of each acknowledge cycle the block makes one decision. It answers if it is requesting at exactly the level being serviced. It then presents a 16-bit status/ID and, a cycle later, a data-acknowledge strobe. Otherwise it passes the acknowledge to the next slot. Because a responder never passes the acknowledge on, the slot nearest the handler wins among modules sharing a level. The request is released once its own acknowledge cycle closes.

Every open-collector or active-low bus signal appears here as an active-high drive enable. Level 7 is the highest priority and level 1 the lowest. Level 0 means the module does not interrupt.

Top module: `irq_slot_responder`

## Requirements
- R1: `irq_oe_o` is one-hot while a request is active, with bit n-1 set for level n (1..7). It is all zero when no request is active or the latched level is 0.
- R2: A `req_i` pulse seen while no acknowledge cycle is in progress latches `level_i` and asserts the request line on the following clock edge.
- R3: An acknowledge cycle begins when `ack_in_i` rises while idle. If a request is active and `ack_lvl_i` equals the latched nonzero level, `data_oe_o` rises one edge later.
- R4: `status_o` carries `cause_i` in bits 15:8 and `laddr_i` in bits 7:0, captured at the start of the answered cycle. It stays stable for the rest of that cycle.
- R5: `dtack_o` rises exactly one edge after `data_oe_o` and is never high without `data_oe_o`.
- R6: When the block does not answer, `ack_out_o` rises one edge after `ack_in_i` rises, and no data is driven.
- R7: While answering, `ack_out_o` stays low.
- R8: One edge after `ack_in_i` falls, `ack_out_o`, `data_oe_o` and `dtack_o` are all low. An answered request is dropped from `irq_oe_o` at the same edge.
- R9: The answer-or-forward choice holds for the whole acknowledge cycle, even if the level code or the request state changes meanwhile.
- R10: A request pulse arriving during an acknowledge cycle leaves `irq_oe_o` untouched until that cycle ends. It is asserted at the edge where the cycle closes.
- R11: Reset clears every request, pending request and drive enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle local interrupt request pulse |
| level_i | input | 3 | Interrupt level sampled with `req_i` (0 = none) |
| cause_i | input | 8 | Device cause/status byte |
| laddr_i | input | 8 | Logical address of this module |
| ack_in_i | input | 1 | Incoming acknowledge daisy-chain, active high |
| ack_lvl_i | input | 3 | Level being serviced, from the low address lines |
| irq_oe_o | output | 7 | Request line drive enables, bit n-1 for level n |
| ack_out_o | output | 1 | Acknowledge passed to the downstream slot |
| data_oe_o | output | 1 | Data-line drive enable for the status/ID |
| status_o | output | 16 | Status/ID value |
| dtack_o | output | 1 | Data-acknowledge drive enable |

## Verification
The acknowledge is presented under several conditions. It comes with a matching level while a request is active, which must be answered. It comes with a different level, and it comes while nothing is requested; both must be forwarded. Level 0 is covered, and so are a request that arrives inside an acknowledge cycle and a level code that changes mid-cycle. The matching and mismatching cases separate answering from forwarding. The mid-cycle changes show whether the decision is latched once or re-evaluated every cycle. A request arriving during a cycle checks that it is deferred rather than lost or raised early.

// File: rtl/irq_slot_pkg.sv
package irq_slot_pkg;
    localparam int LVL_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FWD  = 2'd1,
        ST_RESP = 2'd2
    } ack_state_e;

    typedef struct packed {
        ack_state_e       state;
        logic             pend;
        logic [LVL_W-1:0] pend_level;
        logic             active;
        logic [LVL_W-1:0] level;
        logic             ack_out;
        logic             data_oe;
        logic             dtack;
    } slot_regs_t;
endpackage

// File: rtl/irq_level_decode.sv
module irq_level_decode #(
    parameter int N_LEVELS = 7,
    parameter int LVL_W    = 3
) (
    input  logic                en,
    input  logic [LVL_W-1:0]    level,
    output logic [N_LEVELS-1:0] onehot
);
    for (genvar i = 0; i < N_LEVELS; i++) begin : g_line
        assign onehot[i] = en && (level == LVL_W'(i + 1));
    end
endmodule

// File: rtl/status_id_pack.sv
module status_id_pack #(
    parameter int CAUSE_W = 8,
    parameter int LADDR_W = 8,
    localparam int ST_W   = CAUSE_W + LADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [LADDR_W-1:0] laddr,
    output logic [ST_W-1:0]    status
);
    logic [ST_W-1:0] status_d, status_q;

    always_comb begin
        status_d = status_q;
        if (load) status_d = {cause, laddr};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    assign status = status_q;
endmodule

// File: rtl/irq_slot_responder.sv
module irq_slot_responder
    import irq_slot_pkg::*;
#(
    parameter int N_LEVELS = 7,
    parameter int CAUSE_W  = 8,
    parameter int LADDR_W  = 8,
    localparam int ST_W    = CAUSE_W + LADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  logic [LVL_W-1:0]    level_i,
    input  logic [CAUSE_W-1:0]  cause_i,
    input  logic [LADDR_W-1:0]  laddr_i,
    input  logic                ack_in_i,
    input  logic [LVL_W-1:0]    ack_lvl_i,
    output logic [N_LEVELS-1:0] irq_oe_o,
    output logic                ack_out_o,
    output logic                data_oe_o,
    output logic [ST_W-1:0]     status_o,
    output logic                dtack_o
);
    slot_regs_t r_d, r_q;
    logic       load_status;
    logic       match;

    assign match = r_q.active && (r_q.level != '0) && (ack_lvl_i == r_q.level);

    always_comb begin
        r_d         = r_q;
        load_status = 1'b0;
        if (req_i) begin
            r_d.pend       = 1'b1;
            r_d.pend_level = level_i;
        end
        unique case (r_q.state)
            ST_IDLE: begin
                if (ack_in_i) begin
                    if (match) begin
                        r_d.state   = ST_RESP;
                        r_d.data_oe = 1'b1;
                        load_status = 1'b1;
                    end else begin
                        r_d.state   = ST_FWD;
                        r_d.ack_out = 1'b1;
                    end
                end
            end
            ST_FWD: begin
                if (!ack_in_i) begin
                    r_d.state   = ST_IDLE;
                    r_d.ack_out = 1'b0;
                end
            end
            ST_RESP: begin
                if (ack_in_i) begin
                    r_d.dtack = 1'b1;
                end else begin
                    r_d.state   = ST_IDLE;
                    r_d.data_oe = 1'b0;
                    r_d.dtack   = 1'b0;
                    r_d.active  = 1'b0;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
        if (r_d.state == ST_IDLE && !ack_in_i && r_d.pend) begin
            r_d.active = 1'b1;
            r_d.level  = r_d.pend_level;
            r_d.pend   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    irq_level_decode #(.N_LEVELS(N_LEVELS), .LVL_W(LVL_W)) u_dec (
        .en     (r_q.active),
        .level  (r_q.level),
        .onehot (irq_oe_o)
    );

    status_id_pack #(.CAUSE_W(CAUSE_W), .LADDR_W(LADDR_W)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load_status),
        .cause  (cause_i),
        .laddr  (laddr_i),
        .status (status_o)
    );

    assign ack_out_o = r_q.ack_out;
    assign data_oe_o = r_q.data_oe;
    assign dtack_o   = r_q.dtack;

    assert_onehot_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_oe_o));

    assert_answer_on_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_oe_o) |-> $past(ack_in_i && irq_oe_o != '0));

    assert_status_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe_o && $past(data_oe_o)) |-> $stable(status_o));

    assert_dtack_with_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dtack_o |-> data_oe_o);

    assert_no_forward_when_answering_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_out_o && data_oe_o));

    assert_release_on_ack_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_in_i |=> (!ack_out_o && !data_oe_o && !dtack_o));

    assert_forward_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_out_o && ack_in_i) |=> ack_out_o);
endmodule

// File: tb/irq_slot_responder_tb.sv
module irq_slot_responder_tb;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [2:0]  level_i = '0;
    logic [7:0]  cause_i = '0;
    logic [7:0]  laddr_i = '0;
    logic        ack_in_i = 1'b0;
    logic [2:0]  ack_lvl_i = '0;
    logic [6:0]  irq_oe_o;
    logic        ack_out_o;
    logic        data_oe_o;
    logic [15:0] status_o;
    logic        dtack_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_slot_responder u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .level_i(level_i),
        .cause_i(cause_i), .laddr_i(laddr_i), .ack_in_i(ack_in_i),
        .ack_lvl_i(ack_lvl_i), .irq_oe_o(irq_oe_o), .ack_out_o(ack_out_o),
        .data_oe_o(data_oe_o), .status_o(status_o), .dtack_o(dtack_o)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic outs(string tag, logic [6:0] irq, logic fwd, logic doe, logic dt);
        chk({tag, " irq_oe"}, 32'(irq_oe_o), 32'(irq));
        chk({tag, " ack_out"}, 32'(ack_out_o), 32'(fwd));
        chk({tag, " data_oe"}, 32'(data_oe_o), 32'(doe));
        chk({tag, " dtack"}, 32'(dtack_o), 32'(dt));
    endtask

    task automatic request(logic [2:0] lvl);
        level_i = lvl; req_i = 1'b1;
        tick();
        req_i = 1'b0;
    endtask

    task automatic t_reset();
        outs("R11 reset", 7'h00, 0, 0, 0);
        chk("R11 status", 32'(status_o), 32'h0);
    endtask

    task automatic t_answer();
        request(3'd3);
        outs("R1 R2 level3", 7'h04, 0, 0, 0);
        cause_i = 8'hA5; laddr_i = 8'h12; ack_lvl_i = 3'd3; ack_in_i = 1'b1;
        tick();
        outs("R3 R7 answer", 7'h04, 0, 1, 0);
        chk("R4 status", 32'(status_o), 32'hA512);
        cause_i = 8'h00; laddr_i = 8'hFF;
        tick();
        outs("R5 dtack", 7'h04, 0, 1, 1);
        chk("R4 status held", 32'(status_o), 32'hA512);
        ack_in_i = 1'b0;
        tick();
        outs("R8 release", 7'h00, 0, 0, 0);
    endtask

    task automatic t_mismatch();
        request(3'd5);
        outs("R1 level5", 7'h10, 0, 0, 0);
        ack_lvl_i = 3'd2; ack_in_i = 1'b1;
        tick();
        outs("R6 mismatch fwd", 7'h10, 1, 0, 0);
        ack_lvl_i = 3'd5;
        tick();
        outs("R9 decision fixed", 7'h10, 1, 0, 0);
        ack_in_i = 1'b0;
        tick();
        outs("R8 fwd release", 7'h10, 0, 0, 0);
        ack_in_i = 1'b1;
        tick();
        outs("R3 second cycle", 7'h10, 0, 1, 0);
        ack_in_i = 1'b0;
        tick();
        outs("R8 level5 drop", 7'h00, 0, 0, 0);
    endtask

    task automatic t_idle_forward();
        ack_lvl_i = 3'd4; ack_in_i = 1'b1;
        tick();
        outs("R6 not requesting", 7'h00, 1, 0, 0);
        req_i = 1'b1; level_i = 3'd4;
        tick();
        req_i = 1'b0;
        outs("R10 held in cycle", 7'h00, 1, 0, 0);
        tick();
        outs("R9 R10 still fwd", 7'h00, 1, 0, 0);
        ack_in_i = 1'b0;
        tick();
        outs("R10 raised at end", 7'h08, 0, 0, 0);
        ack_in_i = 1'b1;
        tick();
        outs("R3 deferred answered", 7'h08, 0, 1, 0);
        ack_in_i = 1'b0;
        tick();
        outs("R8 deferred drop", 7'h00, 0, 0, 0);
    endtask

    task automatic t_level0();
        request(3'd0);
        outs("R1 level0", 7'h00, 0, 0, 0);
        ack_lvl_i = 3'd0; ack_in_i = 1'b1;
        tick();
        outs("R6 level0 fwd", 7'h00, 1, 0, 0);
        ack_in_i = 1'b0;
        tick();
    endtask

    task automatic t_reset_mid();
        request(3'd7);
        outs("R1 level7", 7'h40, 0, 0, 0);
        ack_lvl_i = 3'd7; ack_in_i = 1'b1;
        tick();
        rst_n = 1'b0;
        #1;
        outs("R11 reset mid", 7'h00, 0, 0, 0);
        ack_in_i = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_answer();
        t_mismatch();
        t_idle_forward();
        t_level0();
        t_reset_mid();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule